// File: doc/BRIEF.md
# Pin Group Direction/Output Writer

This block holds the direction and output-level registers for 64 pins. The registers are split into two 32-bit halves: half A covers pins 0 to 31 and half B covers pins 32 to 63. A single command sets, clears or otherwise rewrites a run of adjacent pins in one of the two register kinds. Each command names a target (direction or output), a value source and an 11-bit argument. The argument's low six bits pick a base pin. Its upper five bits give how many further pins follow the base. A run that reaches the end of its half wraps to the bottom of that same half and never spills into the other half.

A prefix command can replace the count field of the next group write. A controller uses it to give the count at run time instead of packing it into the argument. Every group write reports the base pin's previous bit on both returned flags. A separate test command reads one pin's input level into either flag.

The sequencer has two states. In `ST_PLAIN` the count comes from the argument. In `ST_ARMED` an override count is held. The transitions are:
- `ST_PLAIN` to `ST_ARMED` on a prefix (`T_ARM`).
- `ST_ARMED` to `ST_ARMED` on another prefix, which reloads the override (`T_RELOAD`).
- `ST_ARMED` to `ST_ARMED` on a test or an idle cycle (`T_HOLD`).
- `ST_ARMED` to `ST_PLAIN` on a group write, which consumes the override (`T_USE`).

Top module: `pgw_writer`

## Requirements
- R1: A group write (cmd_kind 0 or 1) changes pin cmd_arg[5:0] and the next cmd_arg[10:6] pins above it, which is count+1 pins in all. The new register values appear one clock after the command is accepted.
- R2: Bit 5 of the base pin picks the half. Pin positions advance modulo 32 inside that half, and the other half never changes.
- R3: A prefix (cmd_kind 2) stores cmd_arg[4:0] as an override count and enters ST_ARMED. The next group write uses the override in place of cmd_arg[10:6].
- R4: A group write consumes the override and returns to ST_PLAIN. A test command or an idle cycle leaves the override pending. A second prefix replaces it.
- R5: The value source is cmd_src: 0 writes 0, 1 writes 1, 2 writes flag_c_in, 3 writes its inverse, 4 writes flag_z_in, 5 writes its inverse, 7 inverts each affected pin's own bit.
- R6: Source 6 writes random bits from a 32-bit LFSR. The LFSR is seeded with 1 at reset and steps on every clock. Each step shifts right and XORs in 0x80200003 when the dropped bit was 1. The pin at range offset i takes bit i of the value held in the accepting cycle.
- R7: One cycle after a group write, rsp_valid is 1, and rsp_c and rsp_z both equal the base pin's target bit as it was before the write.
- R8: A test command (cmd_kind 3) returns the bit pin_in[cmd_arg[5:0]], inverted when cmd_src[1] is 1. It goes into rsp_c when cmd_src[0] is 0 and into rsp_z when cmd_src[0] is 1. The other flag returns its flag input unchanged.
- R9: Kind 0 writes only the direction register and kind 1 writes only the output register. Pins outside the range keep their bits.
- R10: A prefix and an idle cycle give no response and change no register.
- R11: After reset all direction and output bits are 0, rsp_valid is 0 and the sequencer is in ST_PLAIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_kind | input | 2 | 0 direction write, 1 output write, 2 prefix, 3 input test |
| cmd_src | input | 3 | Value source for writes; destination and inversion for tests |
| cmd_arg | input | 11 | Base pin in [5:0], extra count in [10:6] |
| flag_c_in | input | 1 | Incoming C flag |
| flag_z_in | input | 1 | Incoming Z flag |
| pin_in | input | 64 | Pin input levels |
| pin_dir | output | 64 | Direction register bits |
| pin_out | output | 64 | Output register bits |
| rsp_valid | output | 1 | Flags returned for the previous command |
| rsp_c | output | 1 | Returned C flag |
| rsp_z | output | 1 | Returned Z flag |

## Verification
The bench builds the block with its default parameters: 32-bit halves, so there are 64 pins, an 11-bit argument and a 32-bit LFSR. This width makes the longest range, 32 pins covering a whole half, and every wrap point reachable with short commands. Because the LFSR width equals the half width, the bench can predict every random bit from its own model. The stimulus reaches the ST_ARMED state along every listed transition.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        K_WR_DIR = 2'd0,
        K_WR_OUT = 2'd1,
        K_PREFIX = 2'd2,
        K_TEST   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_LOW   = 3'd0,
        S_HIGH  = 3'd1,
        S_C     = 3'd2,
        S_NC    = 3'd3,
        S_Z     = 3'd4,
        S_NZ    = 3'd5,
        S_RAND  = 3'd6,
        S_FLIP  = 3'd7
    } src_e;

    typedef enum logic {
        ST_PLAIN = 1'b0,
        ST_ARMED = 1'b1
    } seq_e;

endpackage

// File: rtl/pgw_lfsr.sv
module pgw_lfsr #(
    parameter int          LW   = 32,
    parameter logic [31:0] TAPS = 32'h8020_0003,
    parameter logic [31:0] SEED = 32'h0000_0001
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [LW-1:0] state
);
    logic [LW-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) begin
            nxt = nxt ^ TAPS[LW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED[LW-1:0];
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/pgw_span.sv
module pgw_span #(
    parameter int HW = 32,
    localparam int CW = $clog2(HW)
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic [HW-1:0] rnd_src,
    output logic [HW-1:0] hit,
    output logic [HW-1:0] rnd
);
    for (genvar j = 0; j < HW; j++) begin : g_pin
        logic [CW-1:0] ofs;
        assign ofs    = CW'(j) - base;
        assign hit[j] = (ofs <= count);
        assign rnd[j] = rnd_src[ofs];
    end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int HW = 32,
    localparam int CW = $clog2(HW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [CW-1:0] pre_cnt,
    input  logic [CW-1:0] arg_cnt,
    output logic [CW-1:0] eff_cnt,
    output seq_e          state
);
    seq_e          nstate;
    logic [CW-1:0] ovr_q;
    logic          is_pre;
    logic          is_grp;

    assign is_pre = cmd_valid && (kind_e'(cmd_kind) == K_PREFIX);
    assign is_grp = cmd_valid && ((kind_e'(cmd_kind) == K_WR_DIR) ||
                                  (kind_e'(cmd_kind) == K_WR_OUT));

    always_comb begin
        nstate = state;
        unique case (state)
            ST_PLAIN: if (is_pre) nstate = ST_ARMED;      // T_ARM
            ST_ARMED: if (is_grp) nstate = ST_PLAIN;      // T_USE
                      else        nstate = ST_ARMED;      // T_RELOAD / T_HOLD
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PLAIN;
            ovr_q <= '0;
        end else begin
            state <= nstate;
            if (is_pre) begin
                ovr_q <= pre_cnt;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_PLAIN: eff_cnt = arg_cnt;
            ST_ARMED: eff_cnt = ovr_q;
        endcase
    end
endmodule

// File: rtl/pgw_writer.sv
module pgw_writer
    import pgw_pkg::*;
#(
    parameter int HW = 32,
    localparam int CW  = $clog2(HW),
    localparam int BW  = CW + 1,
    localparam int AW  = BW + CW,
    localparam int NP  = 2 * HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [2:0]    cmd_src,
    input  logic [AW-1:0] cmd_arg,
    input  logic          flag_c_in,
    input  logic          flag_z_in,
    input  logic [NP-1:0] pin_in,
    output logic [NP-1:0] pin_dir,
    output logic [NP-1:0] pin_out,
    output logic          rsp_valid,
    output logic          rsp_c,
    output logic          rsp_z
);
    logic [HW-1:0] dir_q [2];
    logic [HW-1:0] out_q [2];

    logic          half;
    logic [CW-1:0] lbase;
    logic [CW-1:0] eff_cnt;
    seq_e          seq_state;
    logic [HW-1:0] lfsr;
    logic [HW-1:0] hit;
    logic [HW-1:0] rnd;
    logic [HW-1:0] old_half;
    logic [HW-1:0] new_half;
    logic          grp;
    logic          to_out;
    logic          old_bit;
    logic          test_bit;
    kind_e         kind;

    assign kind   = kind_e'(cmd_kind);
    assign half   = cmd_arg[BW-1];
    assign lbase  = cmd_arg[CW-1:0];
    assign grp    = cmd_valid && ((kind == K_WR_DIR) || (kind == K_WR_OUT));
    assign to_out = (kind == K_WR_OUT);

    pgw_lfsr #(.LW(HW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr)
    );

    pgw_seq #(.HW(HW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .pre_cnt   (cmd_arg[CW-1:0]),
        .arg_cnt   (cmd_arg[AW-1:BW]),
        .eff_cnt   (eff_cnt),
        .state     (seq_state)
    );

    pgw_span #(.HW(HW)) u_span (
        .base    (lbase),
        .count   (eff_cnt),
        .rnd_src (lfsr),
        .hit     (hit),
        .rnd     (rnd)
    );

    always_comb begin
        old_half = to_out ? out_q[half] : dir_q[half];
        old_bit  = old_half[lbase];
        test_bit = pin_in[cmd_arg[BW-1:0]] ^ cmd_src[1];
        for (int j = 0; j < HW; j++) begin
            logic v;
            unique case (src_e'(cmd_src))
                S_LOW:  v = 1'b0;
                S_HIGH: v = 1'b1;
                S_C:    v = flag_c_in;
                S_NC:   v = ~flag_c_in;
                S_Z:    v = flag_z_in;
                S_NZ:   v = ~flag_z_in;
                S_RAND: v = rnd[j];
                S_FLIP: v = ~old_half[j];
            endcase
            new_half[j] = hit[j] ? v : old_half[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q[0]  <= '0;
            dir_q[1]  <= '0;
            out_q[0]  <= '0;
            out_q[1]  <= '0;
            rsp_valid <= 1'b0;
            rsp_c     <= 1'b0;
            rsp_z     <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid && (kind != K_PREFIX);
            if (grp) begin
                if (to_out) out_q[half] <= new_half;
                else        dir_q[half] <= new_half;
                rsp_c <= old_bit;
                rsp_z <= old_bit;
            end else if (cmd_valid && (kind == K_TEST)) begin
                rsp_c <= cmd_src[0] ? flag_c_in : test_bit;
                rsp_z <= cmd_src[0] ? test_bit  : flag_z_in;
            end
        end
    end

    assign pin_dir = {dir_q[1], dir_q[0]};
    assign pin_out = {out_q[1], out_q[0]};

    logic unused_ok;
    assign unused_ok = ^{seq_state};
endmodule

// File: rtl/pgw_writer_chk.sv
module pgw_writer_chk #(
    parameter int HW = 32,
    localparam int CW  = $clog2(HW),
    localparam int BW  = CW + 1,
    localparam int AW  = BW + CW,
    localparam int NP  = 2 * HW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_kind,
    input logic [2:0]    cmd_src,
    input logic [AW-1:0] cmd_arg,
    input logic [NP-1:0] pin_dir,
    input logic [NP-1:0] pin_out,
    input logic          rsp_valid,
    input logic          rsp_c,
    input logic          rsp_z
);
    p_other_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0 && !cmd_arg[BW-1])
        |=> pin_dir[NP-1:HW] == $past(pin_dir[NP-1:HW]));

    p_dir_leaves_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd0) |=> pin_out == $past(pin_out));

    p_flags_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind[1] == 1'b0) |=> (rsp_valid && rsp_c == rsp_z));

    p_base_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd1 && cmd_src == 3'd1)
        |=> pin_out[$past(cmd_arg[BW-1:0])]);

    p_prefix_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2)
        |=> (!rsp_valid && $stable(pin_dir) && $stable(pin_out)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!rsp_valid && $stable(pin_dir) && $stable(pin_out)));
endmodule

bind pgw_writer pgw_writer_chk #(.HW(HW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_src   (cmd_src),
    .cmd_arg   (cmd_arg),
    .pin_dir   (pin_dir),
    .pin_out   (pin_out),
    .rsp_valid (rsp_valid),
    .rsp_c     (rsp_c),
    .rsp_z     (rsp_z)
);

// File: tb/pgw_writer_tb.sv
module pgw_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [2:0]  cmd_src = '0;
    logic [10:0] cmd_arg = '0;
    logic        flag_c_in = 1'b0;
    logic        flag_z_in = 1'b0;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_dir, pin_out;
    logic        rsp_valid, rsp_c, rsp_z;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic        c, z;
        logic [63:0] dir, out;
    } exp_t;
    exp_t sb[$];

    logic [63:0] dir_m = '0, out_m = '0;
    logic [31:0] lfsr_m;
    bit          armed_m = 1'b0;
    int          ovr_m = 0;

    always #10 clk = ~clk;

    pgw_writer u_dut (.*);

    always @(posedge clk) begin
        if (!rst_n) lfsr_m <= 32'h1;
        else        lfsr_m <= (lfsr_m >> 1) ^ (lfsr_m[0] ? 32'h8020_0003 : 32'h0);
    end

    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            compared++;
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL R10: response with nothing expected");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_c !== e.c || rsp_z !== e.z || pin_dir !== e.dir || pin_out !== e.out) begin
                    mismatched++;
                    $display("FAIL %s: got c=%b z=%b dir=%h out=%h exp c=%b z=%b dir=%h out=%h",
                             e.tag, rsp_c, rsp_z, pin_dir, pin_out, e.c, e.z, e.dir, e.out);
                end
            end
        end
    end

    task automatic issue(input int k, input int s, input int arg,
                         input bit c, input bit z, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'(k); cmd_src = 3'(s);
        cmd_arg = 11'(arg); flag_c_in = c; flag_z_in = z;
        if (k == 2) begin
            armed_m = 1'b1; ovr_m = arg & 31;
            return;
        end
        e.tag = tag;
        if (k == 3) begin
            bit b;
            b = pin_in[arg & 63] ^ s[1];
            e.c = s[0] ? c : b;
            e.z = s[0] ? b : z;
        end else begin
            logic [63:0] t, n;
            int base, cnt;
            t = (k == 1) ? out_m : dir_m;
            n = t;
            base = arg & 63;
            cnt = armed_m ? ovr_m : ((arg >> 6) & 31);
            armed_m = 1'b0;
            e.c = t[base]; e.z = t[base];
            for (int i = 0; i <= cnt; i++) begin
                int p;
                logic v;
                p = (base & 32) | ((base + i) & 31);
                case (s)
                    0: v = 1'b0;
                    1: v = 1'b1;
                    2: v = c;
                    3: v = ~c;
                    4: v = z;
                    5: v = ~z;
                    6: v = lfsr_m[i];
                    default: v = ~t[p];
                endcase
                n[p] = v;
            end
            if (k == 1) out_m = n; else dir_m = n;
        end
        e.dir = dir_m; e.out = out_m;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (pin_dir !== '0 || pin_out !== '0 || rsp_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R11: dir=%h out=%h rv=%b exp all zero", pin_dir, pin_out, rsp_valid);
        end
        pin_in = 64'h8000_0001_0000_0010;
        // R1: base 3, four extra pins
        issue(1, 1, (4 << 6) | 3, 0, 0, "R1");
        // R2: wrap in half A, and in half B on direction
        issue(1, 1, (5 << 6) | 30, 0, 0, "R2");
        issue(0, 1, (3 << 6) | 62, 0, 0, "R2");
        // R7: base already set gives old bit 1
        issue(1, 0, (1 << 6) | 5, 0, 0, "R7");
        // R5: flag sources
        issue(0, 2, (2 << 6) | 8, 1, 0, "R5");
        issue(0, 3, (2 << 6) | 12, 1, 0, "R5");
        issue(0, 4, (1 << 6) | 16, 0, 1, "R5");
        issue(0, 5, (1 << 6) | 20, 0, 1, "R5");
        issue(1, 7, (7 << 6) | 0, 0, 0, "R5");
        // R9: output write over whole half B leaves direction
        issue(1, 1, (31 << 6) | 45, 0, 0, "R9");
        // R3/R4/R10: prefix, test keeps override, then consumed
        issue(2, 0, 10, 0, 0, "R3");
        idle(2);
        issue(3, 0, 4, 0, 1, "R8");
        issue(0, 1, 40, 0, 0, "R3");
        issue(0, 0, 40, 0, 0, "R4");
        issue(2, 0, 3, 0, 0, "R4");
        issue(2, 0, 6, 0, 0, "R4");
        issue(0, 1, 24, 0, 0, "R4");
        // R8: test variants
        issue(3, 1, 63, 1, 0, "R8");
        issue(3, 2, 32, 0, 1, "R8");
        issue(3, 3, 5, 1, 1, "R8");
        // R6: random fills
        idle(3);
        issue(0, 6, (31 << 6) | 7, 0, 0, "R6");
        issue(1, 6, (9 << 6) | 50, 0, 0, "R6");
        idle(4);
        compared++;
        if (sb.size() != 0 || pin_dir !== dir_m || pin_out !== out_m) begin
            mismatched++;
            $display("FAIL R10: left=%0d dir=%h out=%h exp dir=%h out=%h",
                     sb.size(), pin_dir, pin_out, dir_m, out_m);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R1: watchdog expired, got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule